// File: doc/BRIEF.md
# Read-After-Write Interlock for a Six-Stage In-Order Pipeline

This block holds the control view of a six-stage in-order pipeline whose stages are, in order, fetch, decode, register read, ALU, memory and writeback. It carries a tag, two source register fields (each with its own use bit), a destination field and a write-enable bit for every instruction in flight. Operands are read in the register-read stage and results are written in the writeback stage. The block compares the sources of the instruction now in register read against the destinations of the instructions in the later stages and decides whether that instruction must wait.

The rule is a distance rule. Let the read stage be number `READ_STG` and the write stage number `WRITE_STG`, so the stage gap is `WRITE_STG - READ_STG` (3 by default). A reader that sits `d` instructions behind a live writer of the same register must wait when `d` is at most the gap. A register-file write lands at the end of the writeback cycle, so a read in that same cycle still gets the old value; this is why the boundary is inclusive. While a wait is in force, fetch, decode and register read keep their contents, a bubble enters the ALU stage, and memory and writeback keep draining. Ordering hazards of the other two kinds cannot arise in this pipeline, because every read comes before every write and writes happen in one stage in program order. No logic is spent on them.

Each stage takes one of three actions every cycle: LOAD (take the stage before it, or the input for fetch), HOLD (keep its contents) or BUBBLE (become empty). On a hazard-free cycle all stages LOAD. On a stall cycle, stages 1 to `READ_STG` HOLD, stage `READ_STG+1` takes BUBBLE and the later stages LOAD. An instruction moves from one stage to the next only on a LOAD.

Top module: `hz_interlock`

## Requirements
- R1: A synchronous active-high reset clears the valid bit of every stage. While reset is held and on the first cycle after it, `stall` is 0 and `stg_valid` is all zero.
- R2: `stall` is 1 when the register-read stage holds a valid instruction, one of its used source fields equals the destination of a valid, write-enabled instruction in the ALU, memory or writeback stage, and that source is not register 0. A lone writer followed at once by a dependent reader stalls the reader for 3 cycles. With 1 unrelated instruction between them the stall lasts 2 cycles, and with 2 between them it lasts 1 cycle.
- R3: With 3 or more instructions between a writer and its reader, the instruction distance exceeds the stage gap and no stall occurs.
- R4: A source or destination of register 0 never causes a stall.
- R5: A writer whose write-enable bit is 0 never causes a stall.
- R6: A source field whose use bit is 0 never causes a stall, even if its register number matches a live destination.
- R7: Either source field (A or B) alone is enough to cause a stall.
- R8: On a stall cycle the fetch, decode and register-read stages keep their valid bit and tag across the clock edge.
- R9: On a stall cycle the ALU stage receives a bubble: after the edge its valid bit and write-enable bit are both 0.
- R10: The memory and writeback stages advance on every cycle. Each valid instruction reaches writeback exactly once, in issue order, with no loss and no duplication.
- R11: The input instruction enters fetch only at an edge where `stall` is 0. An input with `in_valid` at 0 enters as an empty fetch stage. An input presented during a stall is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented for fetch |
| in_tag | input | 8 | Tag of the presented instruction |
| in_src_a | input | 5 | Source register A |
| in_use_a | input | 1 | Source A is read by the instruction |
| in_src_b | input | 5 | Source register B |
| in_use_b | input | 1 | Source B is read by the instruction |
| in_dst | input | 5 | Destination register |
| in_wen | input | 1 | Instruction writes its destination |
| stall | output | 1 | Hold the front stages and insert a bubble into ALU |
| stg_valid | output | 6 | Valid bit per stage; bit 0 is fetch, bit 5 is writeback |
| stg_wen | output | 6 | Write-enable bit per stage, same bit order |
| stg_tag | output | 48 | Tag per stage; bits [8k+7:8k] belong to stage k (0 = fetch) |

## Verification
The bound checker watches, on every cycle, the stage movements that follow from the per-stage actions:
- a stall freezes the read stage and empties the ALU stage;
- an ALU instruction always moves on into memory;
- an input offered while not stalled lands in fetch;
- a stall is only raised when register read is occupied.

Whether a stall is raised for the right reason cannot be seen that way, since it depends on the instruction distance. The bench scenarios show this: the exact 3/2/1/0 stall counts at each distance, the inclusive boundary at writeback, the exemptions for register 0, disabled writes and unused sources, and the complete in-order retirement after each stall episode.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int HZ_REG_W = 5;
    localparam int HZ_TAG_W = 8;

    typedef struct packed {
        logic                valid;
        logic [HZ_TAG_W-1:0] tag;
        logic [HZ_REG_W-1:0] src_a;
        logic                use_a;
        logic [HZ_REG_W-1:0] src_b;
        logic                use_b;
        logic [HZ_REG_W-1:0] dst;
        logic                wen;
    } hz_slot_t;

    typedef enum logic [1:0] {
        ACT_LOAD   = 2'd0,
        ACT_HOLD   = 2'd1,
        ACT_BUBBLE = 2'd2
    } hz_act_t;

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
    import hz_pkg::*;
(
    input  logic                src_used,
    input  logic [HZ_REG_W-1:0] src_reg,
    input  logic                wr_live,
    input  logic [HZ_REG_W-1:0] wr_reg,
    output logic                hit
);
    logic src_nonzero;

    always_comb begin
        src_nonzero = (src_reg != '0);
        hit = src_used && src_nonzero && wr_live && (wr_reg == src_reg);
    end
endmodule

// File: rtl/hz_detect.sv
module hz_detect
    import hz_pkg::*;
#(
    parameter int NWIN = 3
) (
    input  logic                rd_valid,
    input  logic [HZ_REG_W-1:0] rd_src_a,
    input  logic                rd_use_a,
    input  logic [HZ_REG_W-1:0] rd_src_b,
    input  logic                rd_use_b,
    input  logic                win_live [NWIN],
    input  logic [HZ_REG_W-1:0] win_dst  [NWIN],
    output logic                hazard
);
    logic [NWIN-1:0] hit_a;
    logic [NWIN-1:0] hit_b;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        hz_src_match u_match_a (
            .src_used (rd_use_a),
            .src_reg  (rd_src_a),
            .wr_live  (win_live[w]),
            .wr_reg   (win_dst[w]),
            .hit      (hit_a[w])
        );
        hz_src_match u_match_b (
            .src_used (rd_use_b),
            .src_reg  (rd_src_b),
            .wr_live  (win_live[w]),
            .wr_reg   (win_dst[w]),
            .hit      (hit_b[w])
        );
    end

    always_comb begin
        hazard = rd_valid && ((|hit_a) || (|hit_b));
    end
endmodule

// File: rtl/hz_stage_ctl.sv
module hz_stage_ctl
    import hz_pkg::*;
#(
    parameter int READ_STG  = 3,
    parameter int WRITE_STG = 6
) (
    input  logic    hazard,
    output logic    stall,
    output hz_act_t act [WRITE_STG]
);
    typedef enum logic [1:0] {
        REG_FRONT = 2'd0,
        REG_GAP   = 2'd1,
        REG_BACK  = 2'd2
    } region_t;

    function automatic region_t region_of(input int s);
        if (s < READ_STG)       return REG_FRONT;
        else if (s == READ_STG) return REG_GAP;
        else                    return REG_BACK;
    endfunction

    always_comb begin
        stall = hazard;
    end

    for (genvar s = 0; s < WRITE_STG; s++) begin : g_act
        localparam region_t RG = region_of(s);
        always_comb begin
            unique case (RG)
                REG_FRONT: act[s] = hazard ? ACT_HOLD   : ACT_LOAD;
                REG_GAP:   act[s] = hazard ? ACT_BUBBLE : ACT_LOAD;
                REG_BACK:  act[s] = ACT_LOAD;
                default:   act[s] = ACT_LOAD;
            endcase
        end
    end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
#(
    parameter int READ_STG  = 3,
    parameter int WRITE_STG = 6
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    input  logic [HZ_TAG_W-1:0]            in_tag,
    input  logic [HZ_REG_W-1:0]            in_src_a,
    input  logic                           in_use_a,
    input  logic [HZ_REG_W-1:0]            in_src_b,
    input  logic                           in_use_b,
    input  logic [HZ_REG_W-1:0]            in_dst,
    input  logic                           in_wen,
    output logic                           stall,
    output logic [WRITE_STG-1:0]           stg_valid,
    output logic [WRITE_STG-1:0]           stg_wen,
    output logic [WRITE_STG*HZ_TAG_W-1:0]  stg_tag
);
    localparam int NWIN   = WRITE_STG - READ_STG;
    localparam int RD_IDX = READ_STG - 1;

    hz_slot_t pipe_q [WRITE_STG];
    hz_slot_t in_slot;
    hz_act_t  act    [WRITE_STG];
    logic     hazard;
    logic                win_live [NWIN];
    logic [HZ_REG_W-1:0] win_dst  [NWIN];

    always_comb begin
        in_slot = '{valid: in_valid, tag: in_tag, src_a: in_src_a, use_a: in_use_a,
                    src_b: in_src_b, use_b: in_use_b, dst: in_dst, wen: in_wen};
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_window
        always_comb begin
            win_live[w] = pipe_q[READ_STG + w].valid && pipe_q[READ_STG + w].wen;
            win_dst[w]  = pipe_q[READ_STG + w].dst;
        end
    end

    hz_detect #(.NWIN(NWIN)) u_detect (
        .rd_valid (pipe_q[RD_IDX].valid),
        .rd_src_a (pipe_q[RD_IDX].src_a),
        .rd_use_a (pipe_q[RD_IDX].use_a),
        .rd_src_b (pipe_q[RD_IDX].src_b),
        .rd_use_b (pipe_q[RD_IDX].use_b),
        .win_live (win_live),
        .win_dst  (win_dst),
        .hazard   (hazard)
    );

    hz_stage_ctl #(.READ_STG(READ_STG), .WRITE_STG(WRITE_STG)) u_ctl (
        .hazard (hazard),
        .stall  (stall),
        .act    (act)
    );

    for (genvar s = 0; s < WRITE_STG; s++) begin : g_stage
        hz_slot_t feed;
        always_comb begin
            if (s == 0) feed = in_slot;
            else        feed = pipe_q[(s == 0) ? 0 : s - 1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                pipe_q[s].valid <= 1'b0;
                pipe_q[s].wen   <= 1'b0;
            end else begin
                unique case (act[s])
                    ACT_LOAD:   pipe_q[s] <= feed;
                    ACT_HOLD:   pipe_q[s] <= pipe_q[s];
                    ACT_BUBBLE: begin
                        pipe_q[s].valid <= 1'b0;
                        pipe_q[s].wen   <= 1'b0;
                    end
                    default:    pipe_q[s] <= pipe_q[s];
                endcase
            end
        end

        always_comb begin
            stg_valid[s]                    = pipe_q[s].valid;
            stg_wen[s]                      = pipe_q[s].wen;
            stg_tag[s*HZ_TAG_W +: HZ_TAG_W] = pipe_q[s].tag;
        end
    end
endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk
    import hz_pkg::*;
#(
    parameter int READ_STG  = 3,
    parameter int WRITE_STG = 6
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          in_valid,
    input logic [HZ_TAG_W-1:0]           in_tag,
    input logic                          stall,
    input logic [WRITE_STG-1:0]          stg_valid,
    input logic [WRITE_STG-1:0]          stg_wen,
    input logic [WRITE_STG*HZ_TAG_W-1:0] stg_tag
);
    localparam int RD = READ_STG - 1;
    localparam int AL = READ_STG;
    localparam int ME = READ_STG + 1;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (stg_valid == '0) && !stall);

    p_stall_needs_reader_r2: assert property (@(posedge clk) disable iff (rst)
        stall |-> stg_valid[RD]);

    p_hold_read_r8: assert property (@(posedge clk) disable iff (rst)
        stall |=> stg_valid[RD] && (stg_tag[RD*HZ_TAG_W +: HZ_TAG_W] == $past(stg_tag[RD*HZ_TAG_W +: HZ_TAG_W])));

    p_bubble_alu_r9: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stg_valid[AL] && !stg_wen[AL]);

    p_advance_mem_r10: assert property (@(posedge clk) disable iff (rst)
        stg_valid[AL] |=> stg_valid[ME] && (stg_tag[ME*HZ_TAG_W +: HZ_TAG_W] == $past(stg_tag[AL*HZ_TAG_W +: HZ_TAG_W])));

    p_accept_fetch_r11: assert property (@(posedge clk) disable iff (rst)
        (!stall && in_valid) |=> stg_valid[0] && (stg_tag[0 +: HZ_TAG_W] == $past(in_tag)));
endmodule

bind hz_interlock hz_interlock_chk #(.READ_STG(READ_STG), .WRITE_STG(WRITE_STG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_tag    (in_tag),
    .stall     (stall),
    .stg_valid (stg_valid),
    .stg_wen   (stg_wen),
    .stg_tag   (stg_tag)
);

// File: tb/hz_interlock_test.sv
module hz_interlock_test;
    localparam int FE = 0, DE = 1, RDS = 2, AL = 3, ME = 4, WB = 5;
    localparam int NCASE = 9;
    // writer dst/wen, gap, reader srcA/useA/srcB/useB, expected stall cycles
    localparam int T_DST [NCASE] = '{5, 5, 5, 5, 0, 5, 5, 7, 7};
    localparam int T_WEN [NCASE] = '{1, 1, 1, 1, 1, 0, 1, 1, 1};
    localparam int T_GAP [NCASE] = '{0, 1, 2, 3, 0, 0, 0, 0, 0};
    localparam int T_SA  [NCASE] = '{5, 0, 5, 5, 0, 5, 5, 5, 3};
    localparam int T_UA  [NCASE] = '{1, 0, 1, 1, 1, 1, 0, 1, 1};
    localparam int T_SB  [NCASE] = '{0, 5, 0, 0, 0, 0, 0, 9, 7};
    localparam int T_UB  [NCASE] = '{0, 1, 0, 0, 0, 0, 0, 1, 1};
    localparam int T_EXP [NCASE] = '{3, 2, 1, 0, 0, 0, 0, 0, 3};

    logic clk = 0;
    logic rst = 1;
    logic in_valid = 0;
    logic [7:0] in_tag = 0;
    logic [4:0] in_src_a = 0, in_src_b = 0, in_dst = 0;
    logic in_use_a = 0, in_use_b = 0, in_wen = 0;
    logic stall;
    logic [5:0] stg_valid, stg_wen;
    logic [47:0] stg_tag;

    int total = 0, bad = 0, stalls = 0, ret_cnt = 0, ret_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hz_interlock uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag),
        .in_src_a(in_src_a), .in_use_a(in_use_a), .in_src_b(in_src_b), .in_use_b(in_use_b),
        .in_dst(in_dst), .in_wen(in_wen), .stall(stall),
        .stg_valid(stg_valid), .stg_wen(stg_wen), .stg_tag(stg_tag)
    );

    function automatic int tag_at(input int k);
        return int'(stg_tag[k*8 +: 8]);
    endfunction

    task automatic chk(input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (stall) stalls++;
        if (stg_valid[WB]) begin
            if (tag_at(WB) != ret_cnt + 1) ret_bad++;
            ret_cnt++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; in_valid = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;
        stalls = 0; ret_cnt = 0; ret_bad = 0;
    endtask

    task automatic issue(input int tag, input int sa, input int ua, input int sb,
                         input int ub, input int dst, input int wen);
        bit acc;
        in_valid = 1; in_tag = 8'(tag);
        in_src_a = 5'(sa); in_use_a = 1'(ua); in_src_b = 5'(sb); in_use_b = 1'(ub);
        in_dst = 5'(dst); in_wen = 1'(wen);
        do begin
            acc = !stall;
            step();
        end while (!acc);
        in_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // table walk: R2 R3 R4 R5 R6 R7 R10
        for (int i = 0; i < NCASE; i++) begin
            int n;
            do_reset();
            n = 0;
            issue(++n, 0, 0, 0, 0, T_DST[i], T_WEN[i]);
            for (int g = 0; g < T_GAP[i]; g++) issue(++n, 0, 0, 0, 0, 0, 0);
            issue(++n, T_SA[i], T_UA[i], T_SB[i], T_UB[i], 0, 0);
            repeat (8) step();
            chk(stalls, T_EXP[i], $sformatf("R2/R3/R4/R5/R6/R7 case %0d stall cycles", i));
            chk(ret_cnt * 1000 + ret_bad, n * 1000, $sformatf("R10 case %0d retire order", i));
        end

        // R1 reset state
        do_reset();
        chk(int'(stall), 0, "R1 stall after reset");
        chk(int'(stg_valid), 0, "R1 valid after reset");

        // R11 empty input gives empty fetch, valid input lands
        in_valid = 0; step();
        chk(int'(stg_valid[FE]), 0, "R11 empty fetch");
        do_reset();

        // directed stall episode
        in_valid = 1; in_tag = 21; in_src_a = 0; in_use_a = 0; in_src_b = 0; in_use_b = 0;
        in_dst = 5; in_wen = 1; step();
        chk(tag_at(FE), 21, "R11 accepted into fetch");
        in_tag = 22; in_src_a = 5; in_use_a = 1; in_dst = 0; in_wen = 0; step();
        in_tag = 23; in_src_a = 0; in_use_a = 0; step();
        chk(int'(stall), 0, "R2 no stall with empty window");
        in_tag = 24; step();
        chk(int'(stall), 1, "R2 stall on adjacent writer");
        chk(tag_at(RDS), 22, "R2 reader in read stage");
        in_tag = 25; step();
        chk(int'(stall), 1, "R2 stall continues");
        chk(int'({stg_valid[AL], stg_wen[AL]}), 0, "R9 ALU bubble");
        chk(tag_at(FE) * 10000 + tag_at(DE) * 100 + tag_at(RDS), 242322, "R8 front stages held");
        chk(int'(stg_valid[ME]) * 100 + tag_at(ME), 121, "R10 memory advances");
        step();
        chk(int'(stg_valid[WB]) * 100 + tag_at(WB), 121, "R10 writeback advances");
        chk(tag_at(FE), 24, "R11 input not taken during stall");
        chk(int'(stall), 1, "R2 stall with writer in writeback");

        // R1 reset in the middle of a stall
        rst = 1; in_valid = 0;
        @(posedge clk); @(negedge clk);
        chk(int'(stg_valid) * 10 + int'(stall), 0, "R1 reset during stall");
        rst = 0;
        step();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule